// File: doc/BRIEF.md
# Banked External SRAM Byte-Access Bridge

This block gives a host single-byte read and write access to external asynchronous SRAM made of up to four 32K-byte chips. The host writes one 32-bit command word that carries a 2-bit bank field, a 15-bit in-chip address, a direction bit, a start bit and a write byte. It then polls a busy flag in the status word it reads back from the same location. When a read finishes, the fetched byte appears in that status word.

The bank field and the in-chip address together form a 17-bit linear address. A size mode input selects how that address maps onto physical chips. A one-chip system always uses chip 0. A four-chip system uses the upper two address bits as the chip number. A two-chip system places its chips at positions 1 and 2: the lower 32K goes to chip 2 and the upper 32K goes to chip 1. Each access selects exactly one chip, so no access can span two chips.

The SRAM pins are driven with fixed wait timing, set by a parameter. A command that arrives while an access is still running is dropped, and a sticky error flag records that this happened.

Top module: `banked_sram_bridge`

## Requirements
- R1: Command word layout: bits 14:0 in-chip address, bit 15 direction (1 = read, 0 = write), bits 23:16 write byte, bit 26 start, bits 29:28 bank field. A host write without bit 26 set starts nothing and leaves the status word unchanged.
- R2: Status bit 31 (busy) goes high on the clock edge that accepts a command and stays high for exactly WAIT_CYCLES cycles (default 4).
- R3: A host write while busy is ignored. It does not change the latched address, direction or chip, and it writes no memory. It sets status bit 30 (overrun), which stays set until reset.
- R4: Size mode 2'b10 (four chips): the chip number equals bits 16:15 of the linear address {bank, address}, which is the bank field.
- R5: Size mode 2'b00 (two chips): linear address bit 15 clear selects chip 2, and bit 15 set selects chip 1. Linear address bit 16 is ignored.
- R6: Size modes 2'b01 and 2'b11 (one chip) always select chip 0.
- R7: During an access, exactly one active-low chip select is low and the SRAM address equals the in-chip address. When idle, all chip selects are high. Status bits 29:28 show the chip resolved for the last accepted command, and bits 15:0 echo its direction and address.
- R8: A write holds write-enable low for WAIT_CYCLES-2 cycles, starting one cycle after the access begins. Output-enable stays high during a write. The bridge drives the SRAM data bus only while write-enable is low and leaves it high-impedance at every other time.
- R9: A read holds output-enable low for the whole access. It samples the data bus at the last busy cycle, and the byte shows in status bits 23:16 once busy clears. A later write leaves that byte unchanged.
- R10: After reset the status word is zero, all chip selects, write-enable and output-enable are high, and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host write strobe for the command word |
| hostWrData | input | 32 | Command word |
| sizeMode | input | 2 | Memory size mode (00 two chips, 01 one chip, 10 four chips, 11 one chip) |
| statusWord | output | 32 | Busy, overrun, resolved chip, read byte, echoed direction and address |
| sramCeN | output | 4 | Active-low chip selects, one per chip |
| sramAddr | output | 15 | In-chip SRAM address |
| sramWeN | output | 1 | Active-low write enable |
| sramOeN | output | 1 | Active-low output enable |
| sramDq | inout | 8 | Bidirectional SRAM data bus |

## Verification
The bench sweeps every size mode against every bank field. Each case writes a distinct byte and reads it back. The bench also records which chip select and address the memory model saw, so a wrong bank decode shows at the ports within the first access, as a wrong chip select and a wrong byte on read-back. A wait counter that is off by one shows as the wrong number of busy cycles or write-enable cycles on the very next command. A wrong bus-drive condition shows as a driven data bus outside the write pulse, which a per-cycle monitor counts. Lost overrun or ignore state shows when the dropped command's address appears in the status word, or when its byte lands in memory.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic [1:0] {
    SZ_TWO_CHIP  = 2'b00,
    SZ_ONE_CHIP  = 2'b01,
    SZ_FOUR_CHIP = 2'b10,
    SZ_ONE_ALT   = 2'b11
  } sizeMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic active;
    logic isRead;
    logic weActive;
    logic oeActive;
    logic capture;
  } strobes_t;

  localparam int CMD_ADDR_LSB  = 0;
  localparam int CMD_DIR_BIT   = 15;
  localparam int CMD_DATA_LSB  = 16;
  localparam int CMD_START_BIT = 26;
  localparam int CMD_BANK_LSB  = 28;
  localparam int ST_OVR_BIT    = 30;
  localparam int ST_BUSY_BIT   = 31;
endpackage

// File: rtl/bsb_bank_map.sv
module bsb_bank_map #(
  parameter int NUM_CHIPS = 4,
  localparam int BANK_W = $clog2(NUM_CHIPS)
) (
  input  logic [1:0]        sizeMode,
  input  logic [BANK_W-1:0] bankField,
  output logic [BANK_W-1:0] chipSel
);
  import bsb_pkg::*;

  always_comb begin
    unique case (sizeMode_e'(sizeMode))
      SZ_FOUR_CHIP: chipSel = bankField;
      SZ_TWO_CHIP:  chipSel = bankField[0] ? BANK_W'(1) : BANK_W'(2);
      default:      chipSel = '0;
    endcase
  end
endmodule

// File: rtl/bsb_ctrl.sv
module bsb_ctrl #(
  parameter int WAIT_CYCLES = 4,
  localparam int CW = $clog2(WAIT_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               startBit,
  input  logic               readBit,
  output bsb_pkg::strobes_t  stb,
  output logic               busy,
  output logic               overrun
);
  import bsb_pkg::*;

  localparam logic [CW-1:0] WAIT_C = CW'(WAIT_CYCLES);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [CW-1:0] waitCnt;
  logic          opRead;
  logic          acceptNow;

  assign busy      = (waitCnt != '0);
  assign acceptNow = hostWrEn && startBit && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      opRead  <= 1'b0;
    end else if (acceptNow) begin
      waitCnt <= WAIT_C;
      opRead  <= readBit;
    end else if (busy) begin
      waitCnt <= waitCnt - ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 overrun <= 1'b0;
    else if (hostWrEn && busy) overrun <= 1'b1;
  end

  always_comb begin
    stb.accept   = acceptNow;
    stb.active   = busy;
    stb.isRead   = opRead;
    stb.oeActive = busy && opRead;
    stb.weActive = busy && !opRead && (waitCnt < WAIT_C) && (waitCnt > ONE_C);
    stb.capture  = busy && opRead && (waitCnt == ONE_C);
  end
endmodule

// File: rtl/bsb_datapath.sv
module bsb_datapath #(
  parameter int NUM_CHIPS = 4,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  localparam int BANK_W   = $clog2(NUM_CHIPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsb_pkg::strobes_t stb,
  input  logic [31:0]       hostWrData,
  input  logic [1:0]        sizeMode,
  input  logic [DATA_W-1:0] dqIn,
  output logic [NUM_CHIPS-1:0] ceN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              weN,
  output logic              oeN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [BANK_W-1:0] latChip,
  output logic              latDir,
  output logic [DATA_W-1:0] rdByte
);
  import bsb_pkg::*;

  logic [BANK_W-1:0] mappedChip;
  logic [DATA_W-1:0] wrByte;

  bsb_bank_map #(.NUM_CHIPS(NUM_CHIPS)) i_map (
    .sizeMode (sizeMode),
    .bankField(hostWrData[CMD_BANK_LSB +: BANK_W]),
    .chipSel  (mappedChip)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
      latChip <= '0;
      latDir  <= 1'b0;
      wrByte  <= '0;
    end else if (stb.accept) begin
      addrOut <= hostWrData[CMD_ADDR_LSB +: ADDR_W];
      latChip <= mappedChip;
      latDir  <= hostWrData[CMD_DIR_BIT];
      wrByte  <= hostWrData[CMD_DATA_LSB +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdByte <= '0;
    else if (stb.capture) rdByte <= dqIn;
  end

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_ce
    assign ceN[g] = !(stb.active && (latChip == BANK_W'(g)));
  end

  assign weN   = !stb.weActive;
  assign oeN   = !stb.oeActive;
  assign dqOut = wrByte;
  assign dqOe  = stb.weActive;
endmodule

// File: rtl/banked_sram_bridge.sv
module banked_sram_bridge #(
  parameter int WAIT_CYCLES = 4,
  parameter int NUM_CHIPS   = 4,
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [31:0]          hostWrData,
  input  logic [1:0]           sizeMode,
  output logic [31:0]          statusWord,
  output logic [NUM_CHIPS-1:0] sramCeN,
  output logic [ADDR_W-1:0]    sramAddr,
  output logic                 sramWeN,
  output logic                 sramOeN,
  inout  wire  [DATA_W-1:0]    sramDq
);
  import bsb_pkg::*;

  localparam int BANK_W = $clog2(NUM_CHIPS);

  strobes_t          stb;
  logic              busy;
  logic              overrun;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;
  logic [BANK_W-1:0] latChip;
  logic              latDir;
  logic [DATA_W-1:0] rdByte;

  bsb_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWrEn(hostWrEn),
    .startBit(hostWrData[CMD_START_BIT]),
    .readBit (hostWrData[CMD_DIR_BIT]),
    .stb     (stb),
    .busy    (busy),
    .overrun (overrun)
  );

  bsb_datapath #(
    .NUM_CHIPS(NUM_CHIPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWrData(hostWrData),
    .sizeMode  (sizeMode),
    .dqIn      (sramDq),
    .ceN       (sramCeN),
    .addrOut   (sramAddr),
    .weN       (sramWeN),
    .oeN       (sramOeN),
    .dqOut     (dqOut),
    .dqOe      (dqOe),
    .latChip   (latChip),
    .latDir    (latDir),
    .rdByte    (rdByte)
  );

  assign sramDq = dqOe ? dqOut : 'z;

  always_comb begin
    statusWord = '0;
    statusWord[ST_BUSY_BIT]                = busy;
    statusWord[ST_OVR_BIT]                 = overrun;
    statusWord[CMD_BANK_LSB +: BANK_W]     = latChip;
    statusWord[CMD_DATA_LSB +: DATA_W]     = rdByte;
    statusWord[CMD_DIR_BIT]                = latDir;
    statusWord[CMD_ADDR_LSB +: ADDR_W]     = sramAddr;
  end
endmodule

// File: rtl/bsb_checker.sv
module bsb_checker #(
  parameter int NUM_CHIPS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostWrEn,
  input logic [31:0]          hostWrData,
  input logic [31:0]          statusWord,
  input logic [NUM_CHIPS-1:0] sramCeN,
  input logic                 sramWeN,
  input logic                 sramOeN
);
  logic busyS;
  assign busyS = statusWord[31];

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && hostWrData[26] && !busyS |=> busyS) else $error("accept"); // R2

  AST_NO_START_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && !hostWrData[26] && !busyS |=> !busyS) else $error("start"); // R1

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[30] |=> statusWord[30]) else $error("sticky"); // R3

  AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyS |=> $stable(statusWord[29:28]) && $stable(statusWord[15:0])) else $error("held"); // R3

  AST_ONE_CHIP_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~sramCeN)) else $error("onehot"); // R7

  AST_IDLE_NO_CHIP: assert property (@(posedge clk) disable iff (!rstN)
    !busyS |-> (&sramCeN)) else $error("idle"); // R7

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramWeN && !sramOeN)) else $error("weoe"); // R8

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> busyS && statusWord[15]) else $error("oe"); // R9
endmodule

bind banked_sram_bridge bsb_checker #(.NUM_CHIPS(NUM_CHIPS)) i_bsb_checker (
  .clk       (clk),
  .rstN      (rstN),
  .hostWrEn  (hostWrEn),
  .hostWrData(hostWrData),
  .statusWord(statusWord),
  .sramCeN   (sramCeN),
  .sramWeN   (sramWeN),
  .sramOeN   (sramOeN)
);

// File: tb/test_banked_sram_bridge.sv
`timescale 1ns/1ps
module test_banked_sram_bridge;
  localparam int WAIT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [1:0]  sizeMode = 2'b01;
  logic [31:0] statusWord;
  logic [3:0]  sramCeN;
  logic [14:0] sramAddr;
  logic        sramWeN, sramOeN;
  wire  [7:0]  sramDq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_sram_bridge i_banked_sram_bridge (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .sizeMode(sizeMode), .statusWord(statusWord), .sramCeN(sramCeN),
    .sramAddr(sramAddr), .sramWeN(sramWeN), .sramOeN(sramOeN), .sramDq(sramDq)
  );

  // memory model: 4 chips x 64 bytes, indexed by address bits 5:0
  logic [7:0] mem [4][64];
  int   lastChip = -1;
  int   lastAddr = -1;
  int   selChip;
  int   dqBadCnt = 0;
  int   weLowCnt = 0;
  int   oeDuringWrite = 0;
  logic modelDrive;
  logic [7:0] modelByte;

  always_comb begin
    selChip = -1;
    for (int k = 0; k < 4; k++) if (!sramCeN[k]) selChip = k;
  end
  assign modelDrive = !sramOeN && (selChip >= 0);
  assign modelByte  = (selChip >= 0) ? mem[selChip][sramAddr[5:0]] : 8'h00;
  assign sramDq     = modelDrive ? modelByte : 8'hzz;

  always @(negedge clk) begin
    if (rstN) begin
      if (!sramWeN && selChip >= 0) begin
        mem[selChip][sramAddr[5:0]] <= sramDq;
        lastChip <= selChip;
        lastAddr <= int'(sramAddr);
        weLowCnt <= weLowCnt + 1;
        if (!sramOeN) oeDuringWrite <= oeDuringWrite + 1;
      end
      if (sramWeN && sramOeN && sramDq !== 8'hzz) dqBadCnt <= dqBadCnt + 1;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input int bank, input bit rd, input int addr,
                                        input int data, input bit start);
    logic [31:0] w;
    w = '0;
    w[29:28] = 2'(bank);
    w[26]    = start;
    w[23:16] = 8'(data);
    w[15]    = rd;
    w[14:0]  = 15'(addr);
    return w;
  endfunction

  function automatic int expChip(input int mode, input int bank);
    if (mode == 2) return bank;
    if (mode == 0) return 2 - (bank % 2);
    return 0;
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrData = w;
    @(negedge clk);
    hostWrEn   = 1'b0;
  endtask

  task automatic waitIdle(output int busyCycles);
    busyCycles = 0;
    while (statusWord[31]) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    int bc;
    int weBefore;
    for (int c = 0; c < 4; c++) for (int a = 0; a < 64; a++) mem[c][a] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 status", statusWord, 0);
    check("R10 ce", sramCeN, 4'hF);
    check("R10 we/oe", {sramWeN, sramOeN}, 2'b11);
    check("R10 dq", (sramDq === 8'hzz), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R7 R9 sweep over size modes and banks
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 4; b++) begin
        int addr;
        int val;
        int ec;
        addr = 15'h5A40 | (m * 4 + b);
        val  = (m * 37 + b * 11 + 5) % 256;
        ec   = expChip(m, b);
        sizeMode = 2'(m);
        issue(mkCmd(b, 1'b0, addr, val, 1'b1));
        waitIdle(bc);
        if (m == 2)      check("R4 chip", lastChip, ec);
        else if (m == 0) check("R5 chip", lastChip, ec);
        else             check("R6 chip", lastChip, ec);
        check("R7 addr", lastAddr, addr);
        check("R7 status chip", statusWord[29:28], ec);
        issue(mkCmd(b, 1'b1, addr, 0, 1'b1));
        waitIdle(bc);
        check("R9 readback", statusWord[23:16], val);
        check("R7 status addr/dir", statusWord[15:0], {1'b1, 15'(addr)});
      end
    end

    // R2 R8 busy length and write pulse width
    sizeMode = 2'b10;
    weBefore = weLowCnt;
    issue(mkCmd(3, 1'b0, 15'h0011, 8'hC3, 1'b1));
    waitIdle(bc);
    check("R2 busy cycles", bc, WAIT);
    @(negedge clk);
    check("R8 we low cycles", weLowCnt - weBefore, WAIT - 2);
    check("R8 oe high on write", oeDuringWrite, 0);
    issue(mkCmd(3, 1'b1, 15'h0011, 0, 1'b1));
    waitIdle(bc);
    check("R2 read busy cycles", bc, WAIT);
    check("R9 read byte", statusWord[23:16], 8'hC3);
    // R9 read byte survives a write
    issue(mkCmd(0, 1'b0, 15'h0012, 8'h5E, 1'b1));
    waitIdle(bc);
    check("R9 byte held over write", statusWord[23:16], 8'hC3);

    // R1 no start bit: nothing begins, status unchanged
    issue(mkCmd(1, 1'b0, 15'h0013, 8'hEE, 1'b0));
    check("R1 no busy", statusWord[31], 0);
    check("R1 status addr", statusWord[14:0], 15'h0012);
    check("R1 chip unchanged", statusWord[29:28], 0);
    check("R1 memory untouched", mem[1][6'h13], 8'h00);

    // R3 overrun: command while busy dropped
    check("R3 overrun clear", statusWord[30], 0);
    issue(mkCmd(2, 1'b0, 15'h0021, 8'h77, 1'b1));
    waitIdle(bc);
    sizeMode = 2'b01;
    @(negedge clk); hostWrEn = 1'b1; hostWrData = mkCmd(0, 1'b0, 15'h0030, 8'h11, 1'b1);
    @(negedge clk); hostWrData = mkCmd(0, 1'b0, 15'h0021, 8'h99, 1'b1);
    @(negedge clk); hostWrEn = 1'b0;
    check("R3 overrun set", statusWord[30], 1);
    waitIdle(bc);
    check("R3 dropped addr", statusWord[14:0], 15'h0030);
    check("R3 dropped data", mem[0][6'h21], 8'h00);
    issue(mkCmd(0, 1'b1, 15'h0030, 0, 1'b1));
    waitIdle(bc);
    check("R3 first command done", statusWord[23:16], 8'h11);
    check("R3 overrun sticky", statusWord[30], 1);

    // R8 bus never driven outside write pulse
    check("R8 dq idle undriven", dqBadCnt, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule